// File: doc/BRIEF.md
# IPv4 Header Verify and TTL Rewrite Stage

This stage sits between a header source and a route lookup in a forwarding data plane. It takes a 20-byte IPv4 header as five 32-bit words on a valid/ready input stream. It then decides whether the header is fit to forward. Three tests decide this: the version and header-length nibbles, the time-to-live, and a full ones'-complement recomputation of the header checksum. All three use header contents only. Each header leaves on a 32-bit valid/ready output stream with a drop flag held across all five of its words.

A header that passes has its time-to-live reduced by one. Its checksum field is patched incrementally so the header stays consistent. A header that fails leaves unchanged with the drop flag set, so a later stage can discard it.

The destination address is offered on a side port in the same cycle the fifth word is accepted, for every header. A route lookup can therefore start before the rewritten header is emitted. The field tests and the checksum accumulation are separate sub-blocks. A two-slot header store lets one header drain while the next fills, so minimum-size traffic flows back to back.

Top module: `ipv4_hdr_verify`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `out_valid` is 0 and `dst_valid` is 0.
- R2: Each header is exactly five input words. The same five words leave in the same order, headers leave in arrival order, and `out_last` is 1 on the fifth word only. Words 0, 1, 3 and 4 of a passing header are unchanged.
- R3: A header whose word 0 bits [31:28] (version) are not 4, or whose bits [27:24] (header length in words) are not 5, is flagged for drop.
- R4: A header whose time-to-live (word 2 bits [31:24]) is 0 or 1 is flagged for drop. A header with a time-to-live of 2 or more may pass.
- R5: The ten 16-bit halves of the five words are summed in ones'-complement arithmetic with end-around carry. A header whose sum is not 0xFFFF is flagged for drop.
- R6: On a passing header, word 2 leaves with the time-to-live reduced by one, bits [23:16] unchanged, and bits [15:0] replaced by the checksum that makes the rewritten header sum to 0xFFFF.
- R7: `out_drop` is 1 on all five words of a flagged header, which leaves bit-for-bit unchanged. It is 0 on all five words of a passing header.
- R8: `dst_valid` is 1 exactly in the cycle word 4 is accepted, with `dst_addr` equal to that word.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_last` and `out_drop` hold their values.
- R10: With `out_ready` held at 1, a continuous run of headers is accepted with `in_ready` never falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Stage can take an input word |
| in_data | input | 32 | Header word, big-endian field order |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Header word, rewritten when passing |
| out_last | output | 1 | Fifth word of a header |
| out_drop | output | 1 | Header failed a check |
| dst_valid | output | 1 | Destination address offered |
| dst_addr | output | 32 | Destination address of the header being accepted |

## Verification
The assertions take for granted that every header arrives as exactly five words with no framing marker. They also assume the consumer never treats a word as taken unless `out_valid` and `out_ready` are both high, so their output word count stays aligned with the header boundary. The stimulus keeps to this by always presenting complete headers. It inserts idle cycles only between words, never by truncating a header. It draws mostly well-formed headers with correctly computed checksums, and adds one fault at a time: a wrong version, a wrong length, a time-to-live of 0 or 1, or a corrupted checksum. The time-to-live values 2 and 255 are also sent.

// File: rtl/ipv4_hdr_pkg.sv
package ipv4_hdr_pkg;

  localparam int HDR_WORDS = 5;
  localparam int WORD_W    = 32;
  localparam int IDX_W     = $clog2(HDR_WORDS);
  localparam int IDX_TTL   = 2;
  localparam int IDX_LAST  = HDR_WORDS - 1;

  localparam logic [3:0] IP_VERSION = 4'd4;
  localparam logic [3:0] IP_IHL     = 4'd5;

  typedef struct packed {
    logic        drop;
    logic [15:0] new_cs;
  } slot_meta_t;

  // ones'-complement 16-bit add with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'b0, s[16]};
  endfunction

  // incremental checksum for the high byte of a halfword dropping by one:
  // new = ~(~old + ~m + m'), and ~m + m' is the constant 0xFEFF
  function automatic logic [15:0] cs_after_ttl_dec(input logic [15:0] old_cs);
    return ~oc_add(~old_cs, 16'hFEFF);
  endfunction

endpackage

// File: rtl/ipv4_hdr_fieldchk.sv
module ipv4_hdr_fieldchk
  import ipv4_hdr_pkg::*;
#(
  parameter int MIN_TTL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       top_byte,
  output logic             fields_ok
);

  logic ver_ok;
  logic ttl_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ver_ok <= 1'b0;
      ttl_ok <= 1'b0;
    end else if (wr_en) begin
      if (idx == IDX_W'(0))
        ver_ok <= (top_byte[7:4] == IP_VERSION) && (top_byte[3:0] == IP_IHL);
      if (idx == IDX_W'(IDX_TTL))
        ttl_ok <= (top_byte >= 8'(MIN_TTL));
    end
  end

  // both flags settle before the last word; read in that word's cycle
  assign fields_ok = ver_ok & ttl_ok;

endmodule

// File: rtl/ipv4_hdr_csum.sv
module ipv4_hdr_csum
  import ipv4_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] data,
  output logic              sum_ok,
  output logic [15:0]       new_cs
);

  logic [15:0] acc;
  logic [15:0] base;
  logic [15:0] acc_next;

  assign base     = (idx == IDX_W'(0)) ? 16'h0000 : acc;
  assign acc_next = oc_add(oc_add(base, data[31:16]), data[15:0]);
  assign sum_ok   = (acc_next == 16'hFFFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= 16'h0000;
      new_cs <= 16'h0000;
    end else if (wr_en) begin
      acc <= acc_next;
      if (idx == IDX_W'(IDX_TTL))
        new_cs <= cs_after_ttl_dec(data[15:0]);
    end
  end

endmodule

// File: rtl/ipv4_hdr_buf.sv
module ipv4_hdr_buf
  import ipv4_hdr_pkg::*;
#(
  parameter int SLOT_CNT = 2
) (
  input  logic              clk,
  input  logic              rst,
  // fill side
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  slot_meta_t        wr_meta,
  output logic              wr_ready,
  output logic [IDX_W-1:0]  wr_idx,
  // drain side
  input  logic              rd_en,
  output logic              rd_avail,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output slot_meta_t        rd_meta
);

  localparam int SLOT_W = (SLOT_CNT > 1) ? $clog2(SLOT_CNT) : 1;
  localparam int DEPTH  = SLOT_CNT * HDR_WORDS;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(HDR_WORDS);

  logic [WORD_W-1:0]   mem [DEPTH];
  slot_meta_t          meta [SLOT_CNT];
  logic [SLOT_CNT-1:0] full;
  logic [SLOT_W-1:0]   wr_slot, rd_slot;
  logic [ADDR_W-1:0]   wr_addr, rd_addr;
  logic                wr_last, rd_last;

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(SLOT_CNT - 1)) ? '0 : s + 1'b1;
  endfunction

  assign wr_addr  = ADDR_W'(wr_slot) * STRIDE + ADDR_W'(wr_idx);
  assign rd_addr  = ADDR_W'(rd_slot) * STRIDE + ADDR_W'(rd_idx);
  assign wr_last  = (wr_idx == IDX_W'(IDX_LAST));
  assign rd_last  = (rd_idx == IDX_W'(IDX_LAST));
  assign wr_ready = ~full[wr_slot];
  assign rd_avail = full[rd_slot];
  assign rd_data  = mem[rd_addr];
  assign rd_meta  = meta[rd_slot];

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  generate
    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          full[g] <= 1'b0;
          meta[g] <= '0;
        end else begin
          if (wr_en && wr_last && wr_slot == SLOT_W'(g)) begin
            full[g] <= 1'b1;
            meta[g] <= wr_meta;
          end else if (rd_en && rd_last && rd_slot == SLOT_W'(g)) begin
            full[g] <= 1'b0;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_slot <= '0;
      wr_idx  <= '0;
      rd_slot <= '0;
      rd_idx  <= '0;
    end else begin
      if (wr_en) begin
        wr_idx <= wr_last ? '0 : wr_idx + 1'b1;
        if (wr_last) wr_slot <= next_slot(wr_slot);
      end
      if (rd_en) begin
        rd_idx <= rd_last ? '0 : rd_idx + 1'b1;
        if (rd_last) rd_slot <= next_slot(rd_slot);
      end
    end
  end

endmodule

// File: rtl/ipv4_hdr_verify.sv
module ipv4_hdr_verify
  import ipv4_hdr_pkg::*;
#(
  parameter int SLOT_CNT = 2,
  parameter int MIN_TTL  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              out_drop,
  output logic              dst_valid,
  output logic [WORD_W-1:0] dst_addr
);

  logic              wr_en, wr_ready;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              fields_ok, sum_ok;
  logic [15:0]       new_cs;
  slot_meta_t        wr_meta, rd_meta;
  logic              rd_en, rd_avail;
  logic [WORD_W-1:0] rd_data, patched;

  assign in_ready = wr_ready;
  assign wr_en    = in_valid & wr_ready;

  // sub-stage A: version, length and time-to-live
  ipv4_hdr_fieldchk #(.MIN_TTL(MIN_TTL)) u_fields (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .idx       (wr_idx),
    .top_byte  (in_data[31:24]),
    .fields_ok (fields_ok)
  );

  // sub-stage B: running checksum and incremental patch value
  ipv4_hdr_csum u_csum (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .idx    (wr_idx),
    .data   (in_data),
    .sum_ok (sum_ok),
    .new_cs (new_cs)
  );

  assign wr_meta.drop   = ~(fields_ok & sum_ok);
  assign wr_meta.new_cs = new_cs;

  ipv4_hdr_buf #(.SLOT_CNT(SLOT_CNT)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (in_data),
    .wr_meta  (wr_meta),
    .wr_ready (wr_ready),
    .wr_idx   (wr_idx),
    .rd_en    (rd_en),
    .rd_avail (rd_avail),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .rd_meta  (rd_meta)
  );

  // side port for the route lookup, aligned with the last accepted word
  assign dst_valid = wr_en && (wr_idx == IDX_W'(IDX_LAST));
  assign dst_addr  = in_data;

  always_comb begin
    patched = rd_data;
    if (rd_idx == IDX_W'(IDX_TTL) && !rd_meta.drop)
      patched = {rd_data[31:24] - 8'd1, rd_data[23:16], rd_meta.new_cs};
  end

  assign rd_en = rd_avail & (~out_valid | out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_drop  <= 1'b0;
    end else if (rd_en) begin
      out_valid <= 1'b1;
      out_data  <= patched;
      out_last  <= (rd_idx == IDX_W'(IDX_LAST));
      out_drop  <= rd_meta.drop;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ipv4_hdr_verify_chk.sv
module ipv4_hdr_verify_chk
  import ipv4_hdr_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_top,
  input logic       out_last,
  input logic       out_drop,
  input logic       dst_valid
);

  logic [IDX_W-1:0] ocnt;

  always_ff @(posedge clk) begin
    if (rst) ocnt <= '0;
    else if (out_valid && out_ready) ocnt <= out_last ? '0 : ocnt + 1'b1;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_top) && $stable(out_last) && $stable(out_drop));

  assert_dst_on_accept_R8: assert property (@(posedge clk) disable iff (rst)
    dst_valid |-> in_valid && in_ready);

  assert_last_position_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_last == (ocnt == IDX_W'(IDX_LAST))));

  assert_pass_version_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_drop && ocnt == '0 |-> out_top == {IP_VERSION, IP_IHL});

  assert_pass_ttl_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_drop && ocnt == IDX_W'(IDX_TTL) |-> out_top != 8'd0);

endmodule

bind ipv4_hdr_verify ipv4_hdr_verify_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_top   (out_data[31:24]),
  .out_last  (out_last),
  .out_drop  (out_drop),
  .dst_valid (dst_valid)
);

// File: tb/ipv4_hdr_verify_test.sv
module ipv4_hdr_verify_test;

  localparam int NH    = 60;
  localparam int NB    = 16;
  localparam int NW    = NH * 5;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_last;
  logic        out_drop;
  logic        dst_valid;
  logic [31:0] dst_addr;

  int checks = 0;
  int errors = 0;

  logic [31:0] hdr_w [NW];
  logic [31:0] exp_w [NW];
  logic        exp_drop [NH];
  string       exp_tag [NH];

  always #10 clk = ~clk;

  ipv4_hdr_verify uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_drop(out_drop),
    .dst_valid(dst_valid), .dst_addr(dst_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] hsum(input logic [31:0] a, b, c, d, e);
    int unsigned s;
    s = a[31:16] + a[15:0] + b[31:16] + b[15:0] + c[31:16] + c[15:0]
      + d[31:16] + d[15:0] + e[31:16] + e[15:0];
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return s[15:0];
  endfunction

  // kinds: 0 good, 1 bad version, 2 bad length, 3 ttl 0, 4 ttl 1,
  //        5 bad checksum, 6 ttl 2, 7 ttl 255
  task automatic gen(input int h, input int kind);
    logic [31:0] w0, w1, w2, w3, w4, nw2;
    logic [7:0]  ttl, proto;
    logic [3:0]  ver, ihl;
    ver = 4'd4; ihl = 4'd5;
    ttl = 8'(2 + $urandom % 254);
    proto = 8'($urandom);
    if (kind == 1) ver = (4'($urandom) == 4'd4) ? 4'd6 : 4'($urandom | 1) ^ 4'd0;
    if (kind == 1 && ver == 4'd4) ver = 4'd6;
    if (kind == 2) ihl = 4'd6 + 4'($urandom % 10);
    if (kind == 3) ttl = 8'd0;
    if (kind == 4) ttl = 8'd1;
    if (kind == 6) ttl = 8'd2;
    if (kind == 7) ttl = 8'd255;
    w0 = {ver, ihl, 8'($urandom), 16'($urandom)};
    w1 = $urandom; w3 = $urandom; w4 = $urandom;
    w2 = {ttl, proto, 16'h0000};
    w2[15:0] = ~hsum(w0, w1, w2, w3, w4);
    if (kind == 5) begin
      w2[15:0] = w2[15:0] ^ (16'($urandom) | 16'h0010);
      if (hsum(w0, w1, w2, w3, w4) == 16'hFFFF) w2[15:0] = w2[15:0] ^ 16'h0001;
    end
    exp_drop[h] = (kind >= 1 && kind <= 5);
    exp_tag[h]  = (kind == 1 || kind == 2) ? "R3" : (kind == 3 || kind == 4) ? "R4"
                : (kind == 5) ? "R5" : "R6";
    hdr_w[h*5+0] = w0; hdr_w[h*5+1] = w1; hdr_w[h*5+2] = w2;
    hdr_w[h*5+3] = w3; hdr_w[h*5+4] = w4;
    for (int i = 0; i < 5; i++) exp_w[h*5+i] = hdr_w[h*5+i];
    if (!exp_drop[h]) begin
      nw2 = {ttl - 8'd1, proto, 16'h0000};
      nw2[15:0] = ~hsum(w0, w1, nw2, w3, w4);
      exp_w[h*5+2] = nw2;
    end
  endtask

  initial begin
    int in_p, out_p, cycles, stalls, idx, hidx;
    bit hold_pend, burst;
    logic [31:0] held_data;
    logic held_last, held_drop;
    string tag;
    void'($urandom(32'd20240611));
    for (int h = 0; h < NH; h++) begin
      if (h < 8) gen(h, h);
      else if (h < NB) gen(h, 0);
      else gen(h, ($urandom % 10 < 5) ? 0 : int'($urandom % 8));
    end

    repeat (3) @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1, "R1 in_ready", {31'b0, in_ready}, 32'd1);
    check(out_valid == 1'b0, "R1 out_valid", {31'b0, out_valid}, 32'd0);
    check(dst_valid == 1'b0, "R1 dst_valid", {31'b0, dst_valid}, 32'd0);
    rst = 1'b0;

    in_p = 0; out_p = 0; cycles = 0; stalls = 0; hold_pend = 0;
    held_data = '0; held_last = 0; held_drop = 0;
    while (out_p < NW && cycles < LIMIT) begin
      @(negedge clk);
      burst     = (in_p < NB * 5);
      in_valid  = (in_p < NW) && (burst || ($urandom % 4 != 0));
      in_data   = in_valid ? hdr_w[in_p] : $urandom;
      out_ready = burst ? 1'b1 : ($urandom % 3 != 0);
      #2;
      if (burst && in_valid && !in_ready) stalls++;
      if (in_valid && in_ready) begin
        idx = in_p % 5;
        if (idx == 4) begin
          check(dst_valid == 1'b1, "R8 dst_valid on last", {31'b0, dst_valid}, 32'd1);
          check(dst_addr == hdr_w[in_p], "R8 dst_addr", dst_addr, hdr_w[in_p]);
        end else begin
          check(dst_valid == 1'b0, "R8 dst_valid early", {31'b0, dst_valid}, 32'd0);
        end
        in_p++;
      end
      if (hold_pend) begin
        check(out_valid && out_data == held_data && out_last == held_last && out_drop == held_drop,
              "R9 hold under stall", out_data, held_data);
      end
      if (out_valid && out_ready) begin
        hidx = out_p / 5;
        idx  = out_p % 5;
        tag  = exp_drop[hidx] ? exp_tag[hidx] : ((idx == 2) ? "R6" : "R2");
        check(out_data == exp_w[out_p], tag, out_data, exp_w[out_p]);
        check(out_last == (idx == 4), "R2 out_last", {31'b0, out_last}, {31'b0, idx == 4});
        check(out_drop == exp_drop[hidx], "R7 drop flag", {31'b0, out_drop}, {31'b0, exp_drop[hidx]});
        out_p++;
      end
      hold_pend = out_valid && !out_ready;
      held_data = out_data; held_last = out_last; held_drop = out_drop;
      cycles++;
    end
    if (cycles >= LIMIT) check(1'b0, "watchdog", out_p, NW);
    // R10: no input stall during the back-to-back run
    check(stalls == 0, "R10 back-to-back", stalls, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule